// File: doc/BRIEF.md
# PWM Trip-Zone Protection Controller

This block sits between a two-channel PWM generator and its output pins. When a fault arrives, it overrides the pins with a safe state. Faults come from six active-low trip pins and four compare events. Each trip pin can feed a cycle-by-cycle latch or a one-shot latch, or it can be left unused. The cycle-by-cycle latch releases itself at a chosen PWM cycle boundary once the fault has gone. The one-shot latch holds until software clears it.

Compare events can override an output directly through their own action fields. Type-1 events can also feed the one-shot latch, and type-2 events can feed the cycle-by-cycle latch. Each override is a 2-bit action code. An enhanced mode selects a different code depending on whether the time-base counter is counting up or down.

Sticky event flags and per-source cause flags record what happened. They drive a maskable interrupt. A selectable OR of the raw fault sources is brought out as a trip output for other blocks.

Top module: `tz_guard`

## Requirements
- R1: With no trip asserting a non-"keep" action on an output, that output drives its PWM input (`pin_out[o] = pwm_in[o]`) and `pin_oe[o]` is 1. Index o=0 is output A and o=1 is output B. After reset, all flags, `irq` and `trip_out` are 0.
- R2: A trip pin counts only after it has been sampled low on 3 consecutive rising clock edges. In the cycle after the third low edge, its override is visible at the pins. A low pulse of 2 clocks sets no flag and changes no output.
- R3: Action codes are 00 for high impedance (`pin_oe`=0, `pin_out`=0), 01 to force high, 10 to force low, and 11 for no change (the PWM passes through). The latch action for output o is in `act_lat_*[2o+1:2o]`.
- R4: Bit i of `sel_cbc` routes trip pin i to the cycle-by-cycle latch. Bit i of `sel_ost` routes it to the one-shot latch. A pin with neither bit set has no effect.
- R5: The cycle-by-cycle latch clears on a clock edge where its source is absent and the selected boundary strobe is high: `at_zero` when `cbc_rel_prd`=0, `at_period` when it is 1. The other strobe has no effect.
- R6: The one-shot latch stays active until `evt_clr[1]` is sampled high while its source is absent.
- R7: `evt_flg` holds sticky event flags: bit0 for cycle-by-cycle, bit1 for one-shot, and bit 2+k for compare event k. `cbc_why` and `ost_why` hold cause flags: bit i for trip pin i, bit NTRIP for the A-side compare event, and bit NTRIP+1 for the B-side compare event. Each flag sets on the edge after its cause. Each flag clears on an edge where its clear bit is high, unless the cause is present on that edge, in which case it stays set.
- R8: When `enh_en`=1, the `*_up` action fields apply while `cnt_up`=1 and the `*_dn` fields apply while `cnt_up`=0. When `enh_en`=0, the `*_base` fields apply.
- R9: `dc_evt` bit0 is the A type-1 event, bit1 the B type-1 event, bit2 the A type-2 event, and bit3 the B type-2 event. Event k's direct action is in `act_dc_*[2k+1:2k]` and acts on its own side's output at once. Priority on an output is: type-1 direct action, then type-2 direct action, then latch action. A code of 11 gives way to the next source.
- R10: `sel_dc1_ost` (bit0=A, bit1=B) routes type-1 events to the one-shot latch. `sel_dc2_cbc` routes type-2 events to the cycle-by-cycle latch. A routed event sets the latch, its event flag and the matching cause flag.
- R11: `irq` is the OR of `evt_flg & irq_en`, using the same bit map as `evt_flg`.
- R12: `trip_out` is the OR of `tout_sel & {dc_evt, qualified trip pins}`. Bits NTRIP-1:0 are the qualified pins and bits NTRIP+3:NTRIP are the compare events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low reset |
| trip_n | input | NTRIP | Active-low trip pins, already synchronous |
| dc_evt | input | 4 | Compare events (R9 map) |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| at_zero | input | 1 | Counter-zero strobe |
| at_period | input | 1 | Counter-period strobe |
| pwm_in | input | 2 | PWM from generator, bit0 = A |
| sel_cbc | input | NTRIP | Cycle-by-cycle routing per pin |
| sel_ost | input | NTRIP | One-shot routing per pin |
| sel_dc1_ost | input | 2 | Type-1 events to one-shot latch |
| sel_dc2_cbc | input | 2 | Type-2 events to cycle-by-cycle latch |
| cbc_rel_prd | input | 1 | Release boundary, 0 = zero, 1 = period |
| enh_en | input | 1 | Direction-dependent actions enable |
| act_lat_base | input | 4 | Latch action per output, single mode |
| act_lat_up | input | 4 | Latch action per output, counting up |
| act_lat_dn | input | 4 | Latch action per output, counting down |
| act_dc_base | input | 8 | Direct action per compare event, single mode |
| act_dc_up | input | 8 | Direct action per compare event, counting up |
| act_dc_dn | input | 8 | Direct action per compare event, counting down |
| evt_clr | input | 6 | Event flag clears; bit1 also clears one-shot latch |
| cbc_why_clr | input | NTRIP+2 | Cycle-by-cycle cause flag clears |
| ost_why_clr | input | NTRIP+2 | One-shot cause flag clears |
| irq_en | input | 6 | Interrupt enables per event flag |
| tout_sel | input | NTRIP+4 | Trip output source select |
| pin_out | output | 2 | Output pin level |
| pin_oe | output | 2 | Output pin enable, 0 = high impedance |
| evt_flg | output | 6 | Sticky event flags |
| cbc_why | output | NTRIP+2 | Cycle-by-cycle cause flags |
| ost_why | output | NTRIP+2 | One-shot cause flags |
| irq | output | 1 | Interrupt request |
| trip_out | output | 1 | ORed selected trip sources |

## Verification
The assertions assume that trip pins, compare events and boundary strobes are already synchronous to `clk`. They also assume each strobe is a single-cycle pulse, so a latch hold or a flag set can be judged one edge later. The bench changes every input 1 ns after a rising edge and samples outputs after that settling time. It holds each boundary strobe for exactly one cycle. It also keeps trip pins low for whole clock periods, so pulse widths are counted in edges exactly as the qualifier counts them.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int NDC  = 4;
  localparam int NOUT = 2;
  localparam int NEVT = 2 + NDC;

  typedef enum logic [1:0] {
    ACT_HIZ  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_KEEP = 2'b11
  } tz_act_e;

  typedef struct packed {
    logic oe;
    logic lvl;
  } pin_drv_t;

  // choose the action field in force for the current counter direction
  function automatic logic [1:0] pick_code(input logic enh, input logic up,
                                           input logic [1:0] base,
                                           input logic [1:0] upc,
                                           input logic [1:0] dnc);
    if (!enh) return base;
    return up ? upc : dnc;
  endfunction

  // a source claims an output only when active with a code other than keep
  function automatic logic claims(input logic active, input logic [1:0] code);
    return active && (code != ACT_KEEP);
  endfunction

  function automatic pin_drv_t drive_pin(input logic [1:0] code, input logic pwm);
    pin_drv_t d;
    case (tz_act_e'(code))
      ACT_HIZ:  d = '{oe: 1'b0, lvl: 1'b0};
      ACT_HIGH: d = '{oe: 1'b1, lvl: 1'b1};
      ACT_LOW:  d = '{oe: 1'b1, lvl: 1'b0};
      default:  d = '{oe: 1'b1, lvl: pwm};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tz_qual.sv
module tz_qual #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic qual
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (pin_n)      low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign qual = (low_cnt == SAT);
endmodule

// File: rtl/tz_latch.sv
module tz_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic drop,
  output logic lat,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat <= 1'b0;
    else if (src)  lat <= 1'b1;
    else if (drop) lat <= 1'b0;
  end

  // a live source overrides the pins in the same cycle it appears
  assign active = lat | src;
endmodule

// File: rtl/tz_flags.sv
module tz_flags #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= set | (flg & ~clr);
  end
endmodule

// File: rtl/tz_resolve.sv
module tz_resolve
  import tz_pkg::*;
(
  input  logic       pwm,
  input  logic       enh,
  input  logic       up,
  input  logic       lat_on,
  input  logic       dc1_on,
  input  logic       dc2_on,
  input  logic [1:0] lat_base,
  input  logic [1:0] lat_up,
  input  logic [1:0] lat_dn,
  input  logic [1:0] dc1_base,
  input  logic [1:0] dc1_up,
  input  logic [1:0] dc1_dn,
  input  logic [1:0] dc2_base,
  input  logic [1:0] dc2_up,
  input  logic [1:0] dc2_dn,
  output logic       lvl,
  output logic       oe,
  output logic       tripped
);
  logic [1:0] c_lat, c_dc1, c_dc2, code;
  pin_drv_t   drv;

  always_comb begin
    c_lat = pick_code(enh, up, lat_base, lat_up, lat_dn);
    c_dc1 = pick_code(enh, up, dc1_base, dc1_up, dc1_dn);
    c_dc2 = pick_code(enh, up, dc2_base, dc2_up, dc2_dn);
    if (claims(dc1_on, c_dc1))      code = c_dc1;
    else if (claims(dc2_on, c_dc2)) code = c_dc2;
    else if (lat_on)                code = c_lat;
    else                            code = ACT_KEEP;
    drv     = drive_pin(code, pwm);
    lvl     = drv.lvl;
    oe      = drv.oe;
    tripped = (code != ACT_KEEP);
  end
endmodule

// File: rtl/tz_guard.sv
module tz_guard
  import tz_pkg::*;
#(
  parameter int NTRIP   = 6,
  parameter int MIN_LOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTRIP-1:0]  trip_n,
  input  logic [3:0]        dc_evt,
  input  logic              cnt_up,
  input  logic              at_zero,
  input  logic              at_period,
  input  logic [1:0]        pwm_in,
  input  logic [NTRIP-1:0]  sel_cbc,
  input  logic [NTRIP-1:0]  sel_ost,
  input  logic [1:0]        sel_dc1_ost,
  input  logic [1:0]        sel_dc2_cbc,
  input  logic              cbc_rel_prd,
  input  logic              enh_en,
  input  logic [3:0]        act_lat_base,
  input  logic [3:0]        act_lat_up,
  input  logic [3:0]        act_lat_dn,
  input  logic [7:0]        act_dc_base,
  input  logic [7:0]        act_dc_up,
  input  logic [7:0]        act_dc_dn,
  input  logic [5:0]        evt_clr,
  input  logic [NTRIP+1:0]  cbc_why_clr,
  input  logic [NTRIP+1:0]  ost_why_clr,
  input  logic [5:0]        irq_en,
  input  logic [NTRIP+3:0]  tout_sel,
  output logic [1:0]        pin_out,
  output logic [1:0]        pin_oe,
  output logic [5:0]        evt_flg,
  output logic [NTRIP+1:0]  cbc_why,
  output logic [NTRIP+1:0]  ost_why,
  output logic              irq,
  output logic              trip_out
);
  localparam int NCAUSE = NTRIP + 2;

  logic [NTRIP-1:0]  qual;
  logic [NCAUSE-1:0] cbc_cause, ost_cause;
  logic              cbc_src, ost_src, boundary;
  logic              cbc_lat, ost_lat, cbc_act, ost_act;
  logic [NOUT-1:0]   pin_trip;

  // per-pin pulse-width qualification (R2)
  for (genvar i = 0; i < NTRIP; i++) begin : g_qual
    tz_qual #(.MIN_LOW(MIN_LOW)) u_q (
      .clk(clk), .rst_n(rst_n), .pin_n(trip_n[i]), .qual(qual[i])
    );
  end

  // source routing into the two latches (R4, R10)
  assign cbc_cause = {dc_evt[3:2] & sel_dc2_cbc, qual & sel_cbc};
  assign ost_cause = {dc_evt[1:0] & sel_dc1_ost, qual & sel_ost};
  assign cbc_src   = |cbc_cause;
  assign ost_src   = |ost_cause;
  assign boundary  = cbc_rel_prd ? at_period : at_zero;

  tz_latch u_cbc (
    .clk(clk), .rst_n(rst_n), .src(cbc_src), .drop(boundary),
    .lat(cbc_lat), .active(cbc_act)
  );

  tz_latch u_ost (
    .clk(clk), .rst_n(rst_n), .src(ost_src), .drop(evt_clr[1]),
    .lat(ost_lat), .active(ost_act)
  );

  // per-output action resolution (R3, R8, R9)
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    tz_resolve u_r (
      .pwm     (pwm_in[o]),
      .enh     (enh_en),
      .up      (cnt_up),
      .lat_on  (cbc_act | ost_act),
      .dc1_on  (dc_evt[o]),
      .dc2_on  (dc_evt[o+2]),
      .lat_base(act_lat_base[2*o+1 -: 2]),
      .lat_up  (act_lat_up[2*o+1 -: 2]),
      .lat_dn  (act_lat_dn[2*o+1 -: 2]),
      .dc1_base(act_dc_base[2*o+1 -: 2]),
      .dc1_up  (act_dc_up[2*o+1 -: 2]),
      .dc1_dn  (act_dc_dn[2*o+1 -: 2]),
      .dc2_base(act_dc_base[2*(o+2)+1 -: 2]),
      .dc2_up  (act_dc_up[2*(o+2)+1 -: 2]),
      .dc2_dn  (act_dc_dn[2*(o+2)+1 -: 2]),
      .lvl     (pin_out[o]),
      .oe      (pin_oe[o]),
      .tripped (pin_trip[o])
    );
  end

  // sticky flags (R7)
  tz_flags #(.W(NEVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set({dc_evt, ost_src, cbc_src}),
    .clr(evt_clr), .flg(evt_flg)
  );

  tz_flags #(.W(NCAUSE)) u_cbc_why (
    .clk(clk), .rst_n(rst_n), .set(cbc_cause), .clr(cbc_why_clr), .flg(cbc_why)
  );

  tz_flags #(.W(NCAUSE)) u_ost_why (
    .clk(clk), .rst_n(rst_n), .set(ost_cause), .clr(ost_why_clr), .flg(ost_why)
  );

  // interrupt and trip output (R11, R12)
  assign irq      = |(evt_flg & irq_en);
  assign trip_out = |(tout_sel & {dc_evt, qual});
endmodule

// File: rtl/tz_guard_chk.sv
module tz_guard_chk #(
  parameter int NTRIP = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTRIP-1:0] trip_n,
  input logic [NTRIP-1:0] qual,
  input logic [3:0]       dc_evt,
  input logic             cbc_src,
  input logic             ost_src,
  input logic             cbc_lat,
  input logic             ost_lat,
  input logic             boundary,
  input logic [5:0]       evt_clr,
  input logic [5:0]       evt_flg,
  input logic [1:0]       pwm_in,
  input logic [1:0]       pin_out,
  input logic [1:0]       pin_oe,
  input logic [1:0]       pin_trip,
  input logic             irq,
  input logic             trip_out
);
  for (genvar i = 0; i < NTRIP; i++) begin : g_q
    assert_qual_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      qual[i] |-> !$past(trip_n[i]));
  end

  for (genvar o = 0; o < 2; o++) begin : g_o
    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_trip[o] |-> (pin_oe[o] && (pin_out[o] == pwm_in[o])));
    assert_hiz_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[o] |-> (pin_trip[o] && !pin_out[o]));
  end

  assert_cbc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_lat && !boundary) |=> cbc_lat);

  assert_ost_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_lat && !evt_clr[1]) |=> ost_lat);

  assert_cbc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_src |=> evt_flg[0]);

  assert_ost_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ost_src |=> (evt_flg[1] && ost_lat));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|evt_flg));

  assert_tout_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trip_out |-> ((|qual) || (|dc_evt)));
endmodule

bind tz_guard tz_guard_chk #(.NTRIP(NTRIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .qual(qual), .dc_evt(dc_evt),
  .cbc_src(cbc_src), .ost_src(ost_src), .cbc_lat(cbc_lat), .ost_lat(ost_lat),
  .boundary(boundary), .evt_clr(evt_clr), .evt_flg(evt_flg), .pwm_in(pwm_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_trip(pin_trip), .irq(irq),
  .trip_out(trip_out)
);

// File: tb/sim_tz_guard.sv
module sim_tz_guard;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] trip_n = '1;
  logic [3:0] dc_evt = '0;
  logic cnt_up = 1'b1, at_zero = 1'b0, at_period = 1'b0;
  logic [1:0] pwm_in = '0;
  logic [N-1:0] sel_cbc = '0, sel_ost = '0;
  logic [1:0] sel_dc1_ost = '0, sel_dc2_cbc = '0;
  logic cbc_rel_prd = 1'b0, enh_en = 1'b0;
  logic [3:0] act_lat_base = '1, act_lat_up = '1, act_lat_dn = '1;
  logic [7:0] act_dc_base = '1, act_dc_up = '1, act_dc_dn = '1;
  logic [5:0] evt_clr = '0, irq_en = '0;
  logic [N+1:0] cbc_why_clr = '0, ost_why_clr = '0;
  logic [N+3:0] tout_sel = '0;
  logic [1:0] pin_out, pin_oe;
  logic [5:0] evt_flg;
  logic [N+1:0] cbc_why, ost_why;
  logic irq, trip_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tz_guard #(.NTRIP(N)) u0 (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .dc_evt(dc_evt), .cnt_up(cnt_up),
    .at_zero(at_zero), .at_period(at_period), .pwm_in(pwm_in),
    .sel_cbc(sel_cbc), .sel_ost(sel_ost), .sel_dc1_ost(sel_dc1_ost),
    .sel_dc2_cbc(sel_dc2_cbc), .cbc_rel_prd(cbc_rel_prd), .enh_en(enh_en),
    .act_lat_base(act_lat_base), .act_lat_up(act_lat_up), .act_lat_dn(act_lat_dn),
    .act_dc_base(act_dc_base), .act_dc_up(act_dc_up), .act_dc_dn(act_dc_dn),
    .evt_clr(evt_clr), .cbc_why_clr(cbc_why_clr), .ost_why_clr(ost_why_clr),
    .irq_en(irq_en), .tout_sel(tout_sel), .pin_out(pin_out), .pin_oe(pin_oe),
    .evt_flg(evt_flg), .cbc_why(cbc_why), .ost_why(ost_why), .irq(irq),
    .trip_out(trip_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {oe, level} expected for an action code: oe is set unless the code is 00,
  // the level is 1 only for code 01 or for code 11 with a high PWM
  function automatic logic [1:0] exp_pin(input int code, input logic pwm);
    logic oe, lv;
    oe = (code != 0);
    lv = (code == 1) || ((code == 3) && pwm);
    return {oe, lv};
  endfunction

  function automatic logic [31:0] pin(input int o);
    return 32'({pin_oe[o], pin_out[o]});
  endfunction

  task automatic clear_all();
    evt_clr = '1; cbc_why_clr = '1; ost_why_clr = '1;
    tick();
    evt_clr = '0; cbc_why_clr = '0; ost_why_clr = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    pwm_in = 2'b10;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state and pass-through
    chk("R1 pin A after reset", pin(0), 32'b10);
    chk("R1 pin B after reset", pin(1), 32'b11);
    chk("R1 flags after reset", 32'(evt_flg), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 trip_out after reset", 32'(trip_out), 0);

    // R2: pulse width qualification
    sel_ost = 6'b000100; act_lat_base = 4'b1010; pwm_in = 2'b11;
    trip_n[2] = 1'b0; tick(); tick();
    chk("R2 two-edge pulse no trip", pin(0), 32'b11);
    trip_n[2] = 1'b1; tick(); tick();
    chk("R2 two-edge pulse no flag", 32'(evt_flg), 0);
    chk("R2 two-edge pulse pin", pin(1), 32'b11);
    trip_n[2] = 1'b0; repeat (3) tick();
    chk("R2 three-edge pulse trips A", pin(0), 32'b10);
    tick();
    chk("R2 flag after qualified pulse", 32'(evt_flg[1]), 1);
    trip_n[2] = 1'b1; tick();
    evt_clr[1] = 1'b1; tick(); evt_clr[1] = 1'b0;
    clear_all();

    // R4: an unrouted pin has no effect
    sel_ost = '0; sel_cbc = 6'b000010;
    trip_n[0] = 1'b0; repeat (4) tick();
    chk("R4 unrouted pin A", pin(0), 32'b11);
    chk("R4 unrouted pin no flags", 32'(evt_flg), 0);
    chk("R4 unrouted pin no cause", 32'(cbc_why), 0);
    trip_n[0] = 1'b1; tick();

    // R3 R4 R5 R6: sweep of pins, latch kinds and action codes
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 4; c++) begin
          sel_cbc = (m == 0) ? N'(1 << i) : '0;
          sel_ost = (m == 1) ? N'(1 << i) : '0;
          cbc_rel_prd = i[0];
          act_lat_base = {2'(3 - c), 2'(c)};
          pwm_in = 2'(c + i);
          trip_n[i] = 1'b0; repeat (4) tick();
          chk("R3 action on A", pin(0), 32'(exp_pin(c, pwm_in[0])));
          chk("R3 action on B", pin(1), 32'(exp_pin(3 - c, pwm_in[1])));
          chk("R4 event flag kind", 32'(evt_flg[1:0]), (m == 1) ? 2 : 1);
          chk("R4 cause flag", (m == 1) ? 32'(ost_why) : 32'(cbc_why), 32'(1 << i));
          trip_n[i] = 1'b1; tick(); tick();
          chk("R5 R6 latch holds after source gone", pin(0), 32'(exp_pin(c, pwm_in[0])));
          if (m == 0) begin
            if (cbc_rel_prd) at_zero = 1'b1; else at_period = 1'b1;
            tick(); at_zero = 1'b0; at_period = 1'b0;
            chk("R5 other boundary ignored", pin(0), 32'(exp_pin(c, pwm_in[0])));
            if (cbc_rel_prd) at_period = 1'b1; else at_zero = 1'b1;
            tick(); at_zero = 1'b0; at_period = 1'b0;
            chk("R5 release at selected boundary", pin(0), 32'({1'b1, pwm_in[0]}));
          end else begin
            at_zero = 1'b1; at_period = 1'b1;
            tick(); at_zero = 1'b0; at_period = 1'b0;
            chk("R6 boundaries ignored", pin(0), 32'(exp_pin(c, pwm_in[0])));
            evt_clr[1] = 1'b1; tick(); evt_clr[1] = 1'b0;
            chk("R6 release on clear", pin(0), 32'({1'b1, pwm_in[0]}));
          end
          clear_all();
          chk("R7 flags cleared", 32'(evt_flg), 0);
        end
      end
    end

    // R7: clear while cause present keeps flags set
    sel_ost = '0; sel_cbc = 6'b000010; cbc_rel_prd = 1'b0;
    trip_n[1] = 1'b0; repeat (4) tick();
    evt_clr[0] = 1'b1; cbc_why_clr = 8'b10; tick();
    evt_clr[0] = 1'b0; cbc_why_clr = '0;
    chk("R7 event flag set again", 32'(evt_flg[0]), 1);
    chk("R7 cause flag set again", 32'(cbc_why), 32'b10);
    trip_n[1] = 1'b1; tick();
    evt_clr[0] = 1'b1; cbc_why_clr = 8'b10; tick();
    evt_clr[0] = 1'b0; cbc_why_clr = '0;
    chk("R7 flag clears when cause gone", 32'(evt_flg[0]), 0);
    chk("R7 cause clears when cause gone", 32'(cbc_why), 0);
    at_zero = 1'b1; tick(); at_zero = 1'b0;

    // R8: direction-dependent latch actions
    sel_cbc = '0; sel_ost = 6'b001000; pwm_in = 2'b11;
    act_lat_base = 4'b1111; act_lat_up = 4'b0110; act_lat_dn = 4'b1000;
    enh_en = 1'b1;
    trip_n[3] = 1'b0; repeat (4) tick();
    cnt_up = 1'b1; #1;
    chk("R8 up action A", pin(0), 32'b10);
    chk("R8 up action B", pin(1), 32'b11);
    cnt_up = 1'b0; #1;
    chk("R8 down action A", pin(0), 32'b00);
    chk("R8 down action B", pin(1), 32'b10);
    enh_en = 1'b0; #1;
    chk("R8 single field keep", pin(0), 32'b11);
    trip_n[3] = 1'b1; tick();
    evt_clr[1] = 1'b1; tick(); evt_clr[1] = 1'b0;
    clear_all(); cnt_up = 1'b1;

    // R9: direct compare actions and priority
    sel_ost = 6'b000001; act_lat_base = 4'b1010;
    act_dc_base = 8'b01_00_11_01;
    trip_n[0] = 1'b0; repeat (4) tick();
    dc_evt = 4'b0001; #1;
    chk("R9 type-1 beats latch on A", pin(0), 32'b11);
    chk("R9 latch on B", pin(1), 32'b10);
    dc_evt = 4'b0101; #1;
    chk("R9 type-1 beats type-2", pin(0), 32'b11);
    dc_evt = 4'b0100; #1;
    chk("R9 type-2 high impedance", pin(0), 32'b00);
    dc_evt = 4'b0010; #1;
    chk("R9 keep code yields to latch", pin(1), 32'b10);
    dc_evt = 4'b1010; #1;
    chk("R9 type-2 on B", pin(1), 32'b11);
    dc_evt = '0; trip_n[0] = 1'b1; tick();
    evt_clr[1] = 1'b1; tick(); evt_clr[1] = 1'b0;
    clear_all();
    sel_ost = '0; enh_en = 1'b1; act_dc_up = 8'h02; act_dc_dn = 8'h00;
    dc_evt = 4'b0001; cnt_up = 1'b1; #1;
    chk("R8 R9 direct action counting up", pin(0), 32'b10);
    cnt_up = 1'b0; #1;
    chk("R8 R9 direct action counting down", pin(0), 32'b00);
    dc_evt = '0; enh_en = 1'b0; cnt_up = 1'b1; act_dc_base = '1;
    tick(); clear_all();

    // R10 R11: compare events routed into latches
    sel_dc1_ost = 2'b10; act_lat_base = 4'b0110;
    dc_evt = 4'b0010; tick();
    chk("R10 one-shot flag", 32'(evt_flg[1]), 1);
    chk("R10 one-shot cause B", 32'(ost_why), 32'(1 << (N + 1)));
    chk("R10 compare flag", 32'(evt_flg[5:2]), 32'b0010);
    dc_evt = '0; tick();
    chk("R10 one-shot held A", pin(0), 32'b10);
    chk("R10 one-shot held B", pin(1), 32'b11);
    evt_clr[1] = 1'b1; tick(); evt_clr[1] = 1'b0;
    clear_all(); sel_dc1_ost = '0;
    sel_dc2_cbc = 2'b01; dc_evt = 4'b0100; tick();
    chk("R10 cbc flag", 32'(evt_flg[0]), 1);
    chk("R10 cbc cause A", 32'(cbc_why), 32'(1 << N));
    irq_en = 6'b000001; #1;
    chk("R11 irq via latch enable", 32'(irq), 1);
    irq_en = 6'b000100; #1;
    chk("R11 irq masked", 32'(irq), 0);
    irq_en = 6'b010000; #1;
    chk("R11 irq compare flag", 32'(irq), 1);
    dc_evt = '0; at_zero = 1'b1; tick(); at_zero = 1'b0;
    clear_all(); sel_dc2_cbc = '0; irq_en = '0;
    #1;
    chk("R11 irq after clear", 32'(irq), 0);

    // R12: trip output selection sweep
    for (int j = 0; j < N + 4; j++) begin
      if (j < N) begin
        trip_n[j] = 1'b0; repeat (3) tick();
      end else begin
        dc_evt[j - N] = 1'b1; #1;
      end
      tout_sel = (N + 4)'(1 << j); #1;
      chk("R12 selected source", 32'(trip_out), 1);
      tout_sel = ~((N + 4)'(1 << j)); #1;
      chk("R12 other sources", 32'(trip_out), 0);
      tout_sel = '0; trip_n = '1; dc_evt = '0; tick();
    end
    clear_all();

    finish_run();
  end
endmodule